// File: doc/BRIEF.md
# Reference Switch Stop and Latch Unit

This unit sits beside the ramp generator of a stepper motion controller and handles the two end-of-travel reference switches. It synchronises both switch pins, lets software exchange the two pins and choose the active level of each side, and derives stop requests. A stop request is only raised when the commanded direction of travel points into the switch that is active. Stop requests go back to the ramp generator, together with a soft/hard stop selection.

On programmable switch transitions, the unit captures the actual position, and optionally the encoder position, into latch registers. It also keeps a 14-bit status word. Some of its flags are sticky and are cleared by a status-read strobe. Others mirror the ramp generator's live conditions. The OR of the stop, stall and target-reached events drives an interrupt line.

Top module: `refsw_unit`

## Requirements
- R1: After a synchronous reset, `status`, `irq`, all stop outputs and both latch registers read zero.
- R2: Each switch pin passes through two synchroniser flops, and its active state appears in `status` bit 0 (left) or bit 1 (right) three clock edges after the pin changes. Mode bit 2 (left) or bit 3 (right) at 0 makes a high level active; at 1 it makes a low level active.
- R3: With mode bit 4 set, the two pins are exchanged before the polarity of each logical side is applied.
- R4: `stop_left` and `status` bit 4 are high exactly while mode bit 0 is set, the left side is active, `dir_neg` is 1 and `hold_mode` is 0. `stop_right` and bit 5 follow the same rule with mode bit 1, the right side and `dir_neg` at 0. Each event drops when any of these conditions lapses.
- R5: A change of a side's active state (including one caused by a polarity write) is a latch edge. A rising edge counts when mode bit 5 (left) or bit 7 (right) is set; a falling edge counts when bit 6 (left) or bit 8 (right) is set. A counted edge copies `pos_actual` into `latch_pos` and sets latch-ready `status` bit 2 (left) or bit 3 (right).
- R6: When mode bit 9 is set, every counted latch edge also copies `enc_pos` into `latch_enc`. Otherwise `latch_enc` holds its value.
- R7: `stall_in` high while mode bit 10 is set raises the sticky stall event, seen on `status` bit 6 and `stop_stall`.
- R8: A rising edge of `pos_reached` sets the sticky position-reached event, `status` bit 7.
- R9: `status` bits 8, 9, 10, 11 and 13 show `vel_reached`, `pos_reached`, `vel_zero`, `zerowait` and `stall_in` one edge later. Bit 12 is set by a `second_move` pulse and is sticky.
- R10: A cycle with `status_rd` high clears bits 2, 3, 6, 7 and 12 at the next edge, unless a setting condition for that bit is present in the same cycle, in which case the bit stays set.
- R11: `irq` is high in exactly the cycles in which any of `status` bits 4 to 7 is high.
- R12: `stop_soft` follows mode bit 11 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_left | input | 1 | Raw left switch pin |
| pin_right | input | 1 | Raw right switch pin |
| mode | input | 12 | Switch mode word (bit meanings in R2 to R7, R12) |
| pos_actual | input | POS_W | Actual ramp position |
| enc_pos | input | ENC_W | Encoder position |
| dir_neg | input | 1 | Commanded direction: 1 negative, 0 positive |
| hold_mode | input | 1 | Ramp generator is in hold mode |
| stall_in | input | 1 | Stall indication from the driver |
| vel_reached | input | 1 | Target velocity reached |
| pos_reached | input | 1 | Target position reached |
| vel_zero | input | 1 | Actual velocity is zero |
| zerowait | input | 1 | Standstill wait running |
| second_move | input | 1 | Pulse: ramp needed a reverse move |
| status_rd | input | 1 | Status-read strobe, one cycle |
| stop_left | output | 1 | Stop request from left switch |
| stop_right | output | 1 | Stop request from right switch |
| stop_stall | output | 1 | Stop request from stall event |
| stop_soft | output | 1 | Use soft stop ramp |
| latch_pos | output | POS_W | Latched position |
| latch_enc | output | ENC_W | Latched encoder position |
| status | output | 14 | Status word |
| irq | output | 1 | Interrupt |

## Verification
The bench aims at the status-read cycle that coincides with a flag-setting event. A design that lets the read win would silently lose a latch, stall or target event. It switches swap and polarity while a switch is held, so that a design that applies polarity to the wrong pin after a swap, or that misses edges created by a polarity change, shows the wrong active bit or a wrong latch. It flips the commanded direction and hold mode while a switch is active, which exposes stop requests that ignore direction or stay sticky after the cause has gone. Random traffic checks latch values against positions that change every cycle, so sampling the position one cycle early or late is caught.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  localparam int MODE_W = 12;
  localparam int STAT_W = 14;
  localparam int NSIDE  = 2;

  // mode word bit positions
  localparam int M_STOP_L   = 0;
  localparam int M_STOP_R   = 1;
  localparam int M_POL_L    = 2;
  localparam int M_POL_R    = 3;
  localparam int M_SWAP     = 4;
  localparam int M_LAT_L_UP = 5;
  localparam int M_LAT_L_DN = 6;
  localparam int M_LAT_R_UP = 7;
  localparam int M_LAT_R_DN = 8;
  localparam int M_ENC      = 9;
  localparam int M_STALL    = 10;
  localparam int M_SOFT     = 11;

  // status word bit positions
  localparam int S_SW      = 0;
  localparam int S_LAT     = 2;
  localparam int S_STOP    = 4;
  localparam int S_SG      = 6;
  localparam int S_PEV     = 7;
  localparam int S_VR      = 8;
  localparam int S_PR      = 9;
  localparam int S_VZ      = 10;
  localparam int S_ZW      = 11;
  localparam int S_SM      = 12;
  localparam int S_STALLIN = 13;
endpackage

// File: rtl/refsw_sync.sv
module refsw_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/refsw_side.sv
module refsw_side (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic pol_low,
  input  logic stop_en,
  input  logic dir_match,
  input  logic hold,
  input  logic lat_up_en,
  input  logic lat_dn_en,
  output logic active,
  output logic stop_cond,
  output logic latch_hit
);
  logic act_q;

  assign active    = lvl ^ pol_low;
  assign stop_cond = stop_en & active & dir_match & ~hold;
  assign latch_hit = (active & ~act_q & lat_up_en) | (~active & act_q & lat_dn_en);

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= active;
  end

  // R5: a counted edge needs a state change since the previous cycle
  p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (rst)
    latch_hit |-> (active != act_q));
endmodule

// File: rtl/refsw_status.sv
module refsw_status
  import refsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [NSIDE-1:0]  act,
  input  logic [NSIDE-1:0]  stop_c,
  input  logic [NSIDE-1:0]  hit,
  input  logic              stall_en,
  input  logic              stall_in,
  input  logic              pr_in,
  input  logic              vr_in,
  input  logic              vz_in,
  input  logic              zw_in,
  input  logic              sm_in,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [NSIDE-1:0] sw_q, lat_q, stop_q, lat_n;
  logic sg_q, pe_q, vr_q, pr_q, vz_q, zw_q, sm_q, st_q, irq_q;
  logic sg_n, pe_n, sm_n;

  assign lat_n = hit | (lat_q & {NSIDE{~rd}});
  assign sg_n  = (stall_en & stall_in) | (sg_q & ~rd);
  assign pe_n  = (pr_in & ~pr_q) | (pe_q & ~rd);
  assign sm_n  = sm_in | (sm_q & ~rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q <= '0; lat_q <= '0; stop_q <= '0;
      sg_q <= 1'b0; pe_q <= 1'b0; vr_q <= 1'b0; pr_q <= 1'b0;
      vz_q <= 1'b0; zw_q <= 1'b0; sm_q <= 1'b0; st_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sw_q   <= act;
      lat_q  <= lat_n;
      stop_q <= stop_c;
      sg_q   <= sg_n;
      pe_q   <= pe_n;
      sm_q   <= sm_n;
      vr_q   <= vr_in;
      pr_q   <= pr_in;
      vz_q   <= vz_in;
      zw_q   <= zw_in;
      st_q   <= stall_in;
      irq_q  <= (|stop_c) | sg_n | pe_n;
    end
  end

  assign status = {st_q, sm_q, zw_q, vz_q, pr_q, vr_q, pe_q, sg_q, stop_q, lat_q, sw_q};
  assign irq    = irq_q;

  // R10: set wins over a read in the same cycle
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    hit[0] |=> status[S_LAT]);
  // R10: a read with no set clears the latch-ready flag
  p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && !hit[1]) |=> !status[S_LAT+1]);
  // R7: stall with enable raises the stall event
  p_stall_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (stall_en && stall_in) |=> status[S_SG]);
  // R11: interrupt follows the event bits
  p_irq_match_r11: assert property (@(posedge clk) disable iff (rst)
    irq == (|status[S_PEV:S_STOP]));
endmodule

// File: rtl/refsw_unit.sv
module refsw_unit
  import refsw_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int ENC_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_left,
  input  logic              pin_right,
  input  logic [MODE_W-1:0] mode,
  input  logic [POS_W-1:0]  pos_actual,
  input  logic [ENC_W-1:0]  enc_pos,
  input  logic              dir_neg,
  input  logic              hold_mode,
  input  logic              stall_in,
  input  logic              vel_reached,
  input  logic              pos_reached,
  input  logic              vel_zero,
  input  logic              zerowait,
  input  logic              second_move,
  input  logic              status_rd,
  output logic              stop_left,
  output logic              stop_right,
  output logic              stop_stall,
  output logic              stop_soft,
  output logic [POS_W-1:0]  latch_pos,
  output logic [ENC_W-1:0]  latch_enc,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [NSIDE-1:0] raw, lvl, act, stop_c, hit;
  logic [NSIDE-1:0] pol, stop_en, dir_ok, up_en, dn_en;
  logic             soft_q;

  refsw_sync #(.W(NSIDE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({pin_right, pin_left}), .q(raw)
  );

  assign lvl = mode[M_SWAP] ? {raw[0], raw[1]} : raw;

  assign pol     = {mode[M_POL_R], mode[M_POL_L]};
  assign stop_en = {mode[M_STOP_R], mode[M_STOP_L]};
  assign dir_ok  = {~dir_neg, dir_neg};
  assign up_en   = {mode[M_LAT_R_UP], mode[M_LAT_L_UP]};
  assign dn_en   = {mode[M_LAT_R_DN], mode[M_LAT_L_DN]};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    refsw_side u_side (
      .clk(clk), .rst(rst), .lvl(lvl[s]), .pol_low(pol[s]),
      .stop_en(stop_en[s]), .dir_match(dir_ok[s]), .hold(hold_mode),
      .lat_up_en(up_en[s]), .lat_dn_en(dn_en[s]),
      .active(act[s]), .stop_cond(stop_c[s]), .latch_hit(hit[s])
    );
  end

  refsw_status u_stat (
    .clk(clk), .rst(rst), .rd(status_rd), .act(act), .stop_c(stop_c),
    .hit(hit), .stall_en(mode[M_STALL]), .stall_in(stall_in),
    .pr_in(pos_reached), .vr_in(vel_reached), .vz_in(vel_zero),
    .zw_in(zerowait), .sm_in(second_move), .status(status), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_pos <= '0;
      latch_enc <= '0;
      soft_q    <= 1'b0;
    end else begin
      soft_q <= mode[M_SOFT];
      if (|hit) latch_pos <= pos_actual;
      if ((|hit) && mode[M_ENC]) latch_enc <= enc_pos;
    end
  end

  assign stop_left  = status[S_STOP];
  assign stop_right = status[S_STOP+1];
  assign stop_stall = status[S_SG];
  assign stop_soft  = soft_q;

  // R5: a counted edge captures the position of that cycle
  p_latch_value_r5: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> latch_pos == $past(pos_actual));
  // R4: no left stop without enable or during hold
  p_no_stop_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!mode[M_STOP_L] || hold_mode) |=> !stop_left);
  // R6: encoder latch is untouched while disabled
  p_enc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !mode[M_ENC] |=> $stable(latch_enc));
endmodule

// File: tb/test_refsw_unit.sv
module test_refsw_unit;
  localparam int POS_W = 32;
  localparam int ENC_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_l = 0, pin_r = 0;
  logic [11:0] mode = '0;
  logic [POS_W-1:0] pos = '0;
  logic [ENC_W-1:0] enc = '0;
  logic dir_neg = 0, hold = 0, stall = 0, vr = 0, pr = 0, vz = 0, zw = 0, sm = 0, rd = 0;
  logic stop_l, stop_r, stop_sg, stop_soft, irq;
  logic [POS_W-1:0] lpos;
  logic [ENC_W-1:0] lenc;
  logic [13:0] status;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  refsw_unit #(.POS_W(POS_W), .ENC_W(ENC_W)) i_refsw_unit (
    .clk(clk), .rst(rst), .pin_left(pin_l), .pin_right(pin_r), .mode(mode),
    .pos_actual(pos), .enc_pos(enc), .dir_neg(dir_neg), .hold_mode(hold),
    .stall_in(stall), .vel_reached(vr), .pos_reached(pr), .vel_zero(vz),
    .zerowait(zw), .second_move(sm), .status_rd(rd),
    .stop_left(stop_l), .stop_right(stop_r), .stop_stall(stop_sg),
    .stop_soft(stop_soft), .latch_pos(lpos), .latch_enc(lenc),
    .status(status), .irq(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  function automatic logic [1:0] f_active(logic [1:0] s, logic [11:0] md);
    logic l, r;
    l = md[4] ? s[1] : s[0];
    r = md[4] ? s[0] : s[1];
    return {r ^ md[3], l ^ md[2]};
  endfunction

  logic [1:0] m_s1, m_s2, m_actq, m_sw, m_lat, m_stop;
  logic m_sg, m_pe, m_vr, m_pr, m_vz, m_zw, m_sm, m_st, m_irq, m_soft;
  logic [POS_W-1:0] m_lpos;
  logic [ENC_W-1:0] m_lenc;

  always @(posedge clk) begin
    logic [1:0] a, rise, fall, hit, stn, latn;
    logic sgn, pen, smn;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_actq = 0; m_sw = 0; m_lat = 0; m_stop = 0;
      m_sg = 0; m_pe = 0; m_vr = 0; m_pr = 0; m_vz = 0; m_zw = 0; m_sm = 0;
      m_st = 0; m_irq = 0; m_soft = 0; m_lpos = 0; m_lenc = 0;
    end else begin
      a    = f_active(m_s2, mode);
      rise = a & ~m_actq;
      fall = ~a & m_actq;
      hit[0] = (rise[0] & mode[5]) | (fall[0] & mode[6]);
      hit[1] = (rise[1] & mode[7]) | (fall[1] & mode[8]);
      stn[0] = mode[0] & a[0] & dir_neg & ~hold;
      stn[1] = mode[1] & a[1] & ~dir_neg & ~hold;
      latn = hit | (m_lat & {2{~rd}});
      sgn  = (mode[10] & stall) | (m_sg & ~rd);
      pen  = (pr & ~m_pr) | (m_pe & ~rd);
      smn  = sm | (m_sm & ~rd);
      if (|hit) m_lpos = pos;
      if ((|hit) && mode[9]) m_lenc = enc;
      m_irq = (|stn) | sgn | pen;
      m_lat = latn; m_stop = stn; m_sg = sgn; m_pe = pen; m_sm = smn;
      m_sw = a; m_vr = vr; m_pr = pr; m_vz = vz; m_zw = zw; m_st = stall;
      m_soft = mode[11];
      m_actq = a;
      m_s2 = m_s1;
      m_s1 = {pin_r, pin_l};
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R2/R3 switch bits", status[1:0], m_sw);
      chk("R5 latch ready", status[3:2], m_lat);
      chk("R4 stop events", status[5:4], m_stop);
      chk("R4 stop outputs", {stop_r, stop_l}, m_stop);
      chk("R7 stall event", {stop_sg, status[6]}, {m_sg, m_sg});
      chk("R8 position event", status[7], m_pe);
      chk("R9 mirrored bits", status[13:8], {m_st, m_sm, m_zw, m_vz, m_pr, m_vr});
      chk("R11 irq", irq, m_irq);
      chk("R5 latch_pos", lpos, m_lpos);
      chk("R6 latch_enc", lenc, m_lenc);
      chk("R12 soft stop", stop_soft, m_soft);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    chk("R1 status", status, 14'h0);
    chk("R1 irq/stops", {irq, stop_l, stop_r, stop_sg, stop_soft}, 5'h0);
    chk("R1 latches", {lpos, lenc}, 64'h0);
    cmp_on = 1;

    // R2: high-active left switch, three edges later
    pos = 32'h1234_5678; enc = 32'hCAFE_0001;
    mode = 12'h220;              // latch left on rising edge, encoder latch on
    pin_l = 1;
    step(3);
    chk("R2 left active", status[0], 1'b1);
    chk("R5 left latch value", lpos, 32'h1234_5678);
    chk("R6 encoder latch value", lenc, 32'hCAFE_0001);
    // R3: swap with right pin held, left released
    pin_l = 0; pin_r = 1; mode = 12'h010;
    step(4);
    chk("R3 swapped left active", status[1:0], 2'b01);
    // R4: direction qualification on the (swapped) left side
    mode = 12'h011; dir_neg = 1;
    step(2);
    chk("R4 left stop", stop_l, 1'b1);
    dir_neg = 0;
    step(2);
    chk("R4 stop drops on reverse", stop_l, 1'b0);
    // R10: read and set collide
    mode = 12'h400; rd = 0;
    stall = 1; rd = 1;
    step(1);
    chk("R10 set wins over read", status[6], 1'b1);
    stall = 0;
    step(1);
    chk("R10 read clears", status[6], 1'b0);
    rd = 0;
    step(2);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 8) == 0) pin_l = ~pin_l;
      if (($urandom % 8) == 0) pin_r = ~pin_r;
      if (($urandom % 60) == 0) mode = 12'($urandom);
      if (($urandom % 16) == 0) dir_neg = ~dir_neg;
      hold  = (($urandom % 20) == 0);
      pos   = $urandom;
      enc   = $urandom;
      stall = (($urandom % 12) == 0);
      if (($urandom % 10) == 0) pr = ~pr;
      vr = $urandom; vz = $urandom; zw = $urandom;
      sm = (($urandom % 16) == 0);
      rd = (($urandom % 4) == 0);
      step(1);
    end
    rd = 0; sm = 0; stall = 0;
    step(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule